// File: doc/BRIEF.md
# Hysteresis Threshold Monitor with Sticky Change Flag

The block compares a digitized supply or temperature sample with two programmable levels and keeps one status bit that has hysteresis. A trip level sets the status and a separate release level clears it. Between the two levels the status keeps its value. A build-time polarity picks the sense of the comparison. Low-side polarity suits an undervoltage monitor: it trips below the trip level and releases above a higher release level. High-side polarity suits an over-temperature monitor: it trips above the trip level and releases below a lower release level.

Monitoring takes place only while the active-mode qualifier is high. A change of the status bit in either direction sets a sticky event flag. Software clears the flag with a write-one-to-clear pulse. The interrupt output is the flag gated by an enable. One instance per sensor is used, for example one low-side and one high-side instance fed from the same converter.

Top module: `hyst_mon`

## Requirements
- R1: The status bit is updated only at a clock edge where `active_i` is 1; at an edge where `active_i` is 0 it keeps its value, so no new status change arises while inactive.
- R2: With low-side polarity (`POLARITY` = 0), an active edge where `sample_i` < `trip_lvl_i` sets `status_o` to 1.
- R3: With low-side polarity, an active edge where `sample_i` > `release_lvl_i` and not below the trip level clears `status_o` to 0; a sample between the two levels leaves it unchanged.
- R4: With high-side polarity (`POLARITY` = 1), an active edge with `sample_i` > `trip_lvl_i` sets `status_o`, and one with `sample_i` < `release_lvl_i` and not above the trip level clears it; a sample between the levels leaves it unchanged.
- R5: Each change of `status_o`, rising or falling, makes `flag_o` 1 at the next clock edge; the flag never rises without such a change.
- R6: `flag_o` stays 1 until an edge where `flag_clr_i` is 1, which clears it, unless a status change is pending at that same edge, in which case it stays 1.
- R7: `irq_o` is 1 exactly while `flag_o` and `irq_en_i` are both 1, with no added cycle.
- R8: While `rst_n` is 0, `status_o`, `flag_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| active_i | input | 1 | Active-mode qualifier; monitoring runs while 1 |
| sample_i | input | W | Digitized sensor sample |
| trip_lvl_i | input | W | Level that sets the status |
| release_lvl_i | input | W | Level that clears the status |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the event flag |
| status_o | output | 1 | Hysteresis status bit |
| flag_o | output | 1 | Sticky status-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The status is registered once. It is due at the first clock edge after the sample and levels are applied. The flag takes one more edge, because the change is found by comparing the status with its copy from the previous cycle. The interrupt follows the flag and the enable in the same cycle. The bench drives inputs just after each falling edge. A behavioural model of both polarities is stepped on every rising edge, and all outputs are compared with it at the following falling edge. Directed checks wait exactly one edge for the status and two edges for the flag, then read the outputs.

// File: rtl/hyst_mon_pkg.sv
package hyst_mon_pkg;
  typedef enum logic {
    POL_LOW_SIDE  = 1'b0,
    POL_HIGH_SIDE = 1'b1
  } pol_e;
endpackage

// File: rtl/hyst_mon_cmp.sv
module hyst_mon_cmp
  import hyst_mon_pkg::*;
#(
  parameter int   W        = 8,
  parameter pol_e POLARITY = POL_LOW_SIDE
) (
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] trip_lvl_i,
  input  logic [W-1:0] release_lvl_i,
  output logic         trip_hit_o,
  output logic         rel_hit_o
);
  function automatic logic beyond_low(input logic [W-1:0] s, input logic [W-1:0] lvl);
    return s < lvl;
  endfunction

  function automatic logic beyond_high(input logic [W-1:0] s, input logic [W-1:0] lvl);
    return s > lvl;
  endfunction

  generate
    if (POLARITY == POL_HIGH_SIDE) begin : g_high
      assign trip_hit_o = beyond_high(sample_i, trip_lvl_i);
      assign rel_hit_o  = beyond_low(sample_i, release_lvl_i);
    end else begin : g_low
      assign trip_hit_o = beyond_low(sample_i, trip_lvl_i);
      assign rel_hit_o  = beyond_high(sample_i, release_lvl_i);
    end
  endgenerate
endmodule

// File: rtl/hyst_mon_status.sv
module hyst_mon_status (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic trip_hit_i,
  input  logic rel_hit_i,
  output logic status_o,
  output logic change_o
);
  logic stat_q;
  logic stat_prev_q;
  logic stat_d;

  always_comb begin
    stat_d = stat_q;
    if (active_i) begin
      if (trip_hit_i)     stat_d = 1'b1;
      else if (rel_hit_i) stat_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q      <= 1'b0;
      stat_prev_q <= 1'b0;
    end else begin
      stat_q      <= stat_d;
      stat_prev_q <= stat_q;
    end
  end

  assign status_o = stat_q;
  assign change_o = stat_q ^ stat_prev_q;
endmodule

// File: rtl/hyst_mon_flag.sv
module hyst_mon_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (event_i)  flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/hyst_mon.sv
module hyst_mon
  import hyst_mon_pkg::*;
#(
  parameter int   W        = 8,
  parameter pol_e POLARITY = POL_LOW_SIDE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic [W-1:0] sample_i,
  input  logic [W-1:0] trip_lvl_i,
  input  logic [W-1:0] release_lvl_i,
  input  logic         irq_en_i,
  input  logic         flag_clr_i,
  output logic         status_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic trip_hit;
  logic rel_hit;
  logic status_chg;

  hyst_mon_cmp #(.W(W), .POLARITY(POLARITY)) u_cmp (
    .sample_i      (sample_i),
    .trip_lvl_i    (trip_lvl_i),
    .release_lvl_i (release_lvl_i),
    .trip_hit_o    (trip_hit),
    .rel_hit_o     (rel_hit)
  );

  hyst_mon_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active_i),
    .trip_hit_i (trip_hit),
    .rel_hit_i  (rel_hit),
    .status_o   (status_o),
    .change_o   (status_chg)
  );

  hyst_mon_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (status_chg),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/hyst_mon_chk.sv
module hyst_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic active_i,
  input logic trip_hit,
  input logic rel_hit,
  input logic status_chg,
  input logic irq_en_i,
  input logic flag_clr_i,
  input logic status_o,
  input logic flag_o,
  input logic irq_o
);
  a_r1_hold_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> $stable(status_o));

  a_r2_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    active_i && trip_hit |=> status_o);

  a_r3_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    active_i && rel_hit && !trip_hit |=> !status_o);

  a_r5_flag_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    status_chg |=> flag_o);

  a_r5_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !status_chg && !flag_o |=> !flag_o);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && !flag_clr_i |=> flag_o);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_i && !status_chg |=> !flag_o);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o && irq_en_i);
endmodule

bind hyst_mon hyst_mon_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active_i   (active_i),
  .trip_hit   (trip_hit),
  .rel_hit    (rel_hit),
  .status_chg (status_chg),
  .irq_en_i   (irq_en_i),
  .flag_clr_i (flag_clr_i),
  .status_o   (status_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o)
);

// File: tb/hyst_mon_tb.sv
module hyst_mon_tb;
  import hyst_mon_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic active = 1'b0;
  logic [W-1:0] sample = 8'd100;
  logic [W-1:0] lv_trip = 8'd40, lv_rel = 8'd60;
  logic [W-1:0] ht_trip = 8'd200, ht_rel = 8'd180;
  logic irq_en = 1'b0, clr = 1'b0;
  logic lv_stat, lv_flag, lv_irq, ht_stat, ht_flag, ht_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hyst_mon #(.W(W), .POLARITY(POL_LOW_SIDE)) u_dut (
    .clk(clk), .rst_n(rst_n), .active_i(active), .sample_i(sample),
    .trip_lvl_i(lv_trip), .release_lvl_i(lv_rel), .irq_en_i(irq_en),
    .flag_clr_i(clr), .status_o(lv_stat), .flag_o(lv_flag), .irq_o(lv_irq));

  hyst_mon #(.W(W), .POLARITY(POL_HIGH_SIDE)) u_dut_ht (
    .clk(clk), .rst_n(rst_n), .active_i(active), .sample_i(sample),
    .trip_lvl_i(ht_trip), .release_lvl_i(ht_rel), .irq_en_i(irq_en),
    .flag_clr_i(clr), .status_o(ht_stat), .flag_o(ht_flag), .irq_o(ht_irq));

  task automatic check(input logic got, input logic exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", what, got, exp, $time);
    end
  endtask

  // Behavioural reference: per instance a status, the status seen one cycle ago and a flag
  bit m_ls, m_lp, m_lf, m_hs, m_hp, m_hf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ls, m_lp, m_lf, m_hs, m_hp, m_hf} = '0;
    end else begin
      bit nl, nh;
      nl = m_ls;
      nh = m_hs;
      if (active) begin
        if (int'(sample) < int'(lv_trip)) nl = 1;
        else if (int'(sample) > int'(lv_rel)) nl = 0;
        if (int'(sample) > int'(ht_trip)) nh = 1;
        else if (int'(sample) < int'(ht_rel)) nh = 0;
      end
      m_lf = (m_ls != m_lp) ? 1'b1 : (clr ? 1'b0 : m_lf);
      m_hf = (m_hs != m_hp) ? 1'b1 : (clr ? 1'b0 : m_hf);
      m_lp = m_ls;  m_ls = nl;
      m_hp = m_hs;  m_hs = nh;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(lv_stat, m_ls, "R2/R3 model low-side status");
      check(ht_stat, m_hs, "R4 model high-side status");
      check(lv_flag, m_lf, "R5/R6 model low-side flag");
      check(ht_flag, m_hf, "R5/R6 model high-side flag");
      check(lv_irq, m_lf & irq_en, "R7 model low-side irq");
      check(ht_irq, m_hf & irq_en, "R7 model high-side irq");
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_sample(input logic [W-1:0] v);
    #1 sample = v;
  endtask

  task automatic pulse_clr();
    #1 clr = 1'b1;
    tick();
    #1 clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    tick(2);
    // R8 reset state
    check(lv_stat, 1'b0, "R8 status in reset");
    check(lv_flag, 1'b0, "R8 flag in reset");
    check(lv_irq,  1'b0, "R8 irq in reset");
    #1 rst_n = 1'b1; active = 1'b1;
    tick(3);

    // R2 low-side trip, then R5 flag one edge later
    drive_sample(8'd30);
    tick();
    check(lv_stat, 1'b1, "R2 low-side trip sets status");
    check(lv_flag, 1'b0, "R5 flag not yet set");
    tick();
    check(lv_flag, 1'b1, "R5 flag after rising change");
    check(lv_irq, 1'b0, "R7 irq masked while disabled");
    #1 irq_en = 1'b1;
    tick();
    check(lv_irq, 1'b1, "R7 irq with flag and enable");

    // R3 between levels holds
    drive_sample(8'd50);
    tick(3);
    check(lv_stat, 1'b1, "R3 between levels holds");
    check(lv_flag, 1'b1, "R6 flag sticky");
    pulse_clr();
    check(lv_flag, 1'b0, "R6 clear pulse");
    check(lv_irq, 1'b0, "R7 irq drops with flag");

    // R3 release, R5 falling change
    drive_sample(8'd70);
    tick();
    check(lv_stat, 1'b0, "R3 release clears status");
    tick();
    check(lv_flag, 1'b1, "R5 flag after falling change");
    pulse_clr();

    // R4 high-side
    drive_sample(8'd210);
    tick();
    check(ht_stat, 1'b1, "R4 high-side trip sets status");
    drive_sample(8'd190);
    tick(2);
    check(ht_stat, 1'b1, "R4 high-side between levels holds");
    drive_sample(8'd170);
    tick();
    check(ht_stat, 1'b0, "R4 high-side release clears");
    tick(2);
    pulse_clr();
    check(ht_flag, 1'b0, "R6 high-side clear");

    // R1 inactive: status holds, no new events
    #1 active = 1'b0;
    drive_sample(8'd10);
    tick(4);
    check(lv_stat, 1'b0, "R1 status holds while inactive");
    check(lv_flag, 1'b0, "R1 no flag while inactive");
    drive_sample(8'd250);
    tick(3);
    check(ht_stat, 1'b0, "R1 high-side holds while inactive");
    check(ht_flag, 1'b0, "R1 high-side no flag while inactive");

    // R6 change at the same edge as a clear wins
    drive_sample(8'd30);
    #1 active = 1'b1;
    tick();
    check(lv_stat, 1'b1, "R2 trip after reactivation");
    pulse_clr();
    check(lv_flag, 1'b1, "R6 change beats simultaneous clear");
    tick(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule